// File: doc/BRIEF.md
# Privatized Byte Histogram Engine

This block counts how often each 8-bit symbol appears in a byte stream of known length. A start command loads the stream length. The engine then clears a private 256-bin counter bank in every lane, and it clears the shared result bank in the same sweep. Next it accepts exactly the requested number of bytes through a valid/ready handshake. Byte number i of the stream goes to lane i mod N, so neighbouring lanes take neighbouring bytes and each lane steps through the stream with stride N. Each lane counts only into its own bank.

When the last byte has been taken, the engine waits until every lane has drained its pending increment. This barrier must clear before anything is merged. In the merge, each lane walks its bins and adds every non-zero private count into the matching shared bin. Only one lane can write the shared bank in a cycle, so an arbiter grants the lanes one at a time. Because addition is associative and commutative, the final counts do not depend on the order of the grants. A one-cycle done pulse marks the end of the merge. The shared bins can then be read through an address/data port until the next start.

Top module: `hist_engine`

## Requirements
- R1: After reset, `done_o` and `byte_ready` are low and every shared bin reads zero.
- R2: A start accepted in idle clears all private and shared bins over exactly 256 cycles, and `byte_ready` stays low during those cycles. Counts from an earlier run are not carried into the new one.
- R3: The byte value is used directly as the bin index (0 to 255). Each accepted byte adds exactly 1 to that bin.
- R4: The k-th accepted byte (counting from 0) is routed to lane k mod NUM_LANES.
- R5: Exactly `size_i` bytes are accepted. After the last one, `byte_ready` is low, and further valid bytes are neither taken nor counted. A size of 0 gives an all-zero histogram and still ends with a done pulse.
- R6: No shared bin is written by the merge until every lane has finished its last increment.
- R7: The merge adds each private count to the shared bin; it never overwrites it. When several lanes hold counts for the same bin, all of those counts reach the shared bin through the arbiter and none is lost.
- R8: Counters are BIN_W bits wide and wrap modulo 2^BIN_W, both in the private banks and in the merge.
- R9: `done_o` is high for exactly one cycle after the last merge write. The shared bins keep their values on `bin_count` until the next start.
- R10: A start pulse while a run is in progress is ignored. The run finishes with its original size.
- R11: A byte is taken only in a cycle where `byte_valid` and `byte_ready` are both high. Idle cycles in the input stream add nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a run; taken only when idle |
| size_i | input | SIZE_W | Number of bytes in the run, sampled with start |
| byte_valid | input | 1 | Input byte is valid |
| byte_data | input | 8 | Input byte (symbol) |
| byte_ready | output | 1 | Engine takes the byte this cycle if valid |
| bin_addr | input | 8 | Shared bin to read |
| bin_count | output | BIN_W | Count of the addressed shared bin (combinational) |
| done_o | output | 1 | One-cycle pulse when the merge has completed |

## Verification
The hardest case to reach from the ports is the merge: several lanes must hold counts for the same bin, so their adds collide in the arbiter. A run in which every byte has the same value spreads that symbol over all lanes. Every lane then requests the same shared bin in the same merge cycle, and the arbiter has to serialize all of them. A long run of one repeated value, run with a narrow counter width, pushes both the private counts and the merged sum past the wrap point. A start pulse injected in the middle of a stream checks that a busy run cannot be restarted.

// File: rtl/hist_pkg.sv
package hist_pkg;
   localparam int SYM_W    = 8;
   localparam int NUM_BINS = 1 << SYM_W;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CLEAR,
      ST_COUNT,
      ST_BARRIER,
      ST_MERGE
   } hist_state_e;
endpackage

// File: rtl/hist_lane.sv
module hist_lane #(
   parameter int BIN_W = 32,
   parameter int SYM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_v,
   input  logic [SYM_W-1:0] clr_bin,
   input  logic             inc_v,
   input  logic [SYM_W-1:0] inc_bin,
   input  logic             merge_en,
   input  logic             gnt,
   output logic             req,
   output logic [SYM_W-1:0] mrg_bin,
   output logic [BIN_W-1:0] mrg_val,
   output logic             busy,
   output logic             mdone
);
   localparam int NB = 1 << SYM_W;

   logic [BIN_W-1:0] bank [NB];
   logic             inc_q;
   logic [SYM_W-1:0] inc_bin_q;
   logic [SYM_W-1:0] mptr;
   logic             mdone_q;
   logic [BIN_W-1:0] cur;
   logic             walking;
   logic             step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inc_q     <= 1'b0;
         inc_bin_q <= '0;
      end else begin
         inc_q     <= inc_v;
         inc_bin_q <= inc_bin;
      end
   end

   always_ff @(posedge clk) begin
      if (clr_v)
         bank[clr_bin] <= '0;
      else if (inc_q)
         bank[inc_bin_q] <= bank[inc_bin_q] + BIN_W'(1);
   end

   assign cur     = bank[mptr];
   assign walking = merge_en && !mdone_q;
   assign req     = walking && (cur != '0);
   assign step    = walking && ((cur == '0) || gnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mptr    <= '0;
         mdone_q <= 1'b0;
      end else if (clr_v) begin
         mptr    <= '0;
         mdone_q <= 1'b0;
      end else if (step) begin
         mptr <= mptr + SYM_W'(1);
         if (mptr == SYM_W'(NB - 1))
            mdone_q <= 1'b1;
      end
   end

   assign mrg_bin = mptr;
   assign mrg_val = cur;
   assign busy    = inc_q;
   assign mdone   = mdone_q;

   // R2
   lane_no_inc_in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_v |-> !inc_q);

   // R6
   lane_no_merge_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt |-> !inc_q);
endmodule

// File: rtl/hist_arb.sv
module hist_arb #(
   parameter int N  = 4,
   parameter bit RR = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   localparam int PW = (N > 1) ? $clog2(N) : 1;

   generate
      if (RR) begin : g_rr
         logic [PW-1:0] last_q;
         logic [PW-1:0] win;
         logic          found;

         always_comb begin
            gnt   = '0;
            win   = last_q;
            found = 1'b0;
            for (int k = 0; k < N; k++) begin
               int idx;
               idx = (int'(last_q) + 1 + k) % N;
               if (!found && req[idx]) begin
                  gnt[idx] = 1'b1;
                  win      = PW'(idx);
                  found    = 1'b1;
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               last_q <= PW'(N - 1);
            else if (found)
               last_q <= win;
         end
      end else begin : g_fixed
         always_comb begin
            gnt = '0;
            for (int k = N - 1; k >= 0; k--)
               if (req[k]) gnt = N'(1) << k;
         end
      end
   endgenerate

   // R7
   arb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   // R7
   arb_grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);

   // R7
   arb_no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> (gnt != '0));
endmodule

// File: rtl/hist_gbank.sv
module hist_gbank #(
   parameter int BIN_W = 32,
   parameter int SYM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_v,
   input  logic [SYM_W-1:0] clr_bin,
   input  logic             add_v,
   input  logic [SYM_W-1:0] add_bin,
   input  logic [BIN_W-1:0] add_val,
   input  logic [SYM_W-1:0] rd_addr,
   output logic [BIN_W-1:0] rd_data
);
   localparam int NB = 1 << SYM_W;

   logic [BIN_W-1:0] gbin [NB];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) gbin[b] <= '0;
      end else if (clr_v) begin
         gbin[clr_bin] <= '0;
      end else if (add_v) begin
         gbin[add_bin] <= gbin[add_bin] + add_val;
      end
   end

   assign rd_data = gbin[rd_addr];

   // R2
   gbank_no_add_in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_v |-> !add_v);

   // R7
   gbank_nonzero_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
      add_v |-> (add_val != '0));
endmodule

// File: rtl/hist_engine.sv
module hist_engine #(
   parameter int NUM_LANES = 4,
   parameter int BIN_W     = 32,
   parameter int SIZE_W    = 16,
   parameter bit ARB_RR    = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic [SIZE_W-1:0]          size_i,
   input  logic                       byte_valid,
   input  logic [hist_pkg::SYM_W-1:0] byte_data,
   output logic                       byte_ready,
   input  logic [hist_pkg::SYM_W-1:0] bin_addr,
   output logic [BIN_W-1:0]           bin_count,
   output logic                       done_o
);
   import hist_pkg::*;

   localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
   localparam int NB     = NUM_BINS;

   generate
      if (NUM_LANES < 1) begin : g_bad_lanes
         $error("hist_engine: NUM_LANES must be at least 1");
      end
      if (BIN_W < 1 || BIN_W > 32) begin : g_bad_width
         $error("hist_engine: BIN_W must be 1 to 32");
      end
      if (SIZE_W < 1) begin : g_bad_size
         $error("hist_engine: SIZE_W must be at least 1");
      end
   endgenerate

   hist_state_e       state;
   logic [SYM_W-1:0]  clr_ptr;
   logic [SIZE_W-1:0] size_q;
   logic [SIZE_W-1:0] acc_cnt;
   logic [LANE_W-1:0] lane_sel;
   logic              done_q;
   logic              accept;
   logic              clr_v;
   logic              merge_en;

   logic [NUM_LANES-1:0] lane_req;
   logic [NUM_LANES-1:0] lane_gnt;
   logic [NUM_LANES-1:0] lane_busy;
   logic [NUM_LANES-1:0] lane_mdone;
   logic [SYM_W-1:0]     lane_bin [NUM_LANES];
   logic [BIN_W-1:0]     lane_val [NUM_LANES];

   logic                 add_v;
   logic [SYM_W-1:0]     add_bin;
   logic [BIN_W-1:0]     add_val;

   assign byte_ready = (state == ST_COUNT) && (acc_cnt != size_q);
   assign accept     = byte_valid && byte_ready;
   assign clr_v      = (state == ST_CLEAR);
   assign merge_en   = (state == ST_MERGE);
   assign done_o     = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         clr_ptr  <= '0;
         size_q   <= '0;
         acc_cnt  <= '0;
         lane_sel <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start_i) begin
                  size_q   <= size_i;
                  clr_ptr  <= '0;
                  acc_cnt  <= '0;
                  lane_sel <= '0;
                  state    <= ST_CLEAR;
               end
            end
            ST_CLEAR: begin
               clr_ptr <= clr_ptr + SYM_W'(1);
               if (clr_ptr == SYM_W'(NB - 1))
                  state <= ST_COUNT;
            end
            ST_COUNT: begin
               if (accept) begin
                  acc_cnt  <= acc_cnt + SIZE_W'(1);
                  lane_sel <= (lane_sel == LANE_W'(NUM_LANES - 1)) ? '0 : lane_sel + LANE_W'(1);
               end
               if (acc_cnt == size_q)
                  state <= ST_BARRIER;
            end
            ST_BARRIER: begin
               if (lane_busy == '0)
                  state <= ST_MERGE;
            end
            ST_MERGE: begin
               if (&lane_mdone) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   generate
      for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
         hist_lane #(.BIN_W(BIN_W), .SYM_W(SYM_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_v    (clr_v),
            .clr_bin  (clr_ptr),
            .inc_v    (accept && (lane_sel == LANE_W'(i))),
            .inc_bin  (byte_data),
            .merge_en (merge_en),
            .gnt      (lane_gnt[i]),
            .req      (lane_req[i]),
            .mrg_bin  (lane_bin[i]),
            .mrg_val  (lane_val[i]),
            .busy     (lane_busy[i]),
            .mdone    (lane_mdone[i])
         );
      end
   endgenerate

   hist_arb #(.N(NUM_LANES), .RR(ARB_RR)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (lane_req),
      .gnt   (lane_gnt)
   );

   always_comb begin
      add_v   = |lane_gnt;
      add_bin = '0;
      add_val = '0;
      for (int i = 0; i < NUM_LANES; i++) begin
         if (lane_gnt[i]) begin
            add_bin = lane_bin[i];
            add_val = lane_val[i];
         end
      end
   end

   hist_gbank #(.BIN_W(BIN_W), .SYM_W(SYM_W)) u_gbank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_v   (clr_v),
      .clr_bin (clr_ptr),
      .add_v   (add_v),
      .add_bin (add_bin),
      .add_val (add_val),
      .rd_addr (bin_addr),
      .rd_data (bin_count)
   );

   // R4
   lane_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (int'(lane_sel) == (int'(acc_cnt) % NUM_LANES)));

   // R5
   size_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_COUNT) |-> (acc_cnt <= size_q));

   // R6
   merge_after_barrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
      add_v |-> ((lane_busy == '0) && !byte_ready));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R10
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && (state != ST_IDLE)) |=> $stable(size_q));
endmodule

// File: tb/tb_hist_engine.sv
module tb_hist_engine;
   localparam int LANES = 4;
   localparam int BW    = 8;
   localparam int SW    = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [SW-1:0] size_i = '0;
   logic          byte_valid = 1'b0;
   logic [7:0]    byte_data = '0;
   logic          byte_ready;
   logic [7:0]    bin_addr = '0;
   logic [BW-1:0] bin_count;
   logic          done_o;

   int checks = 0;
   int errors = 0;
   int exp_q[$];
   string cur_tag = "R1";
   int req_n = 0;
   int ack_n = 0;
   byte unsigned stim[$];
   bit finished = 1'b0;

   always #4 clk = ~clk;

   hist_engine #(.NUM_LANES(LANES), .BIN_W(BW), .SIZE_W(SW), .ARB_RR(1'b1)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .size_i     (size_i),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .byte_ready (byte_ready),
      .bin_addr   (bin_addr),
      .bin_count  (bin_count),
      .done_o     (done_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_sim();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // monitor: reads every shared bin and compares with the queued expectation
   initial begin
      forever begin
         wait (req_n != ack_n);
         for (int b = 0; b < 256; b++) begin
            int e;
            @(negedge clk);
            bin_addr = 8'(b);
            #1;
            e = exp_q.pop_front();
            chk(int'(bin_count) == e, $sformatf("%s bin %0d", cur_tag, b), int'(bin_count), e);
         end
         ack_n++;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
   end

   task automatic push_byte(input byte unsigned b);
      bit seen;
      byte_data  = b;
      byte_valid = 1'b1;
      do begin
         seen = byte_ready;
         @(negedge clk);
      end while (!seen);
      byte_valid = 1'b0;
   endtask

   task automatic run_case(input string tag, input bit bubbles, input bit check_clear,
                           input bit poke_start);
      int model[256];
      int sz;
      int w;
      int t;
      sz = stim.size();
      foreach (model[b]) model[b] = 0;
      foreach (stim[k]) model[int'(stim[k])]++;

      @(negedge clk);
      start_i = 1'b1;
      size_i  = SW'(sz);
      @(negedge clk);
      start_i = 1'b0;

      if (check_clear) begin
         // R2: ready must stay low for the whole 256-cycle clear sweep
         w = 0;
         while (!byte_ready && w < 400) begin
            @(negedge clk);
            w++;
         end
         chk(w == 256, {tag, " R2 clear cycles"}, w, 256);
      end

      for (int k = 0; k < sz; k++) begin
         if (bubbles && (k % 3 == 1)) begin
            byte_valid = 1'b0;
            byte_data  = 8'hEE;
            @(negedge clk);
            @(negedge clk);
         end
         if (poke_start && k == sz / 2) begin
            start_i = 1'b1;
            size_i  = SW'(3);
         end
         push_byte(stim[k]);
         start_i = 1'b0;
      end

      if (sz > 0)
         chk(byte_ready == 1'b0, {tag, " R5 ready low after last byte"}, int'(byte_ready), 0);

      // R5: extra bytes offered after the run must not be taken
      byte_valid = 1'b1;
      byte_data  = 8'hFF;
      repeat (3) @(negedge clk);
      byte_valid = 1'b0;

      t = 0;
      while (!done_o && t < 20000) begin
         @(negedge clk);
         t++;
      end
      chk(done_o == 1'b1, {tag, " R9 done rises"}, int'(done_o), 1);
      @(negedge clk);
      chk(done_o == 1'b0, {tag, " R9 done one cycle"}, int'(done_o), 0);

      for (int b = 0; b < 256; b++) exp_q.push_back(model[b] % (1 << BW));
      cur_tag = tag;
      req_n++;
      wait (ack_n == req_n);
      chk(done_o == 1'b0, {tag, " R9 no repeat done"}, int'(done_o), 0);
   endtask

   initial begin
      string txt;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(done_o == 1'b0, "R1 done low", int'(done_o), 0);
      chk(byte_ready == 1'b0, "R1 ready low", int'(byte_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(byte_ready == 1'b0, "R1 ready low after reset", int'(byte_ready), 0);
      for (int b = 0; b < 256; b++) exp_q.push_back(0);
      cur_tag = "R1 reset";
      req_n++;
      wait (ack_n == req_n);

      // R3 R4 R11: mixed text with idle cycles
      txt = "PARALLEL HISTOGRAM BYTES";
      stim.delete();
      for (int k = 0; k < txt.len(); k++) stim.push_back(byte'(txt[k]));
      run_case("R3 R4 R11 text", 1'b1, 1'b1, 1'b0);

      // R6 R7: one symbol everywhere, all lanes merge into one bin
      stim.delete();
      for (int k = 0; k < 40; k++) stim.push_back(8'h41);
      run_case("R6 R7 contention", 1'b0, 1'b1, 1'b0);

      // R2 R5: empty run clears earlier counts
      stim.delete();
      run_case("R2 R5 empty", 1'b0, 1'b0, 1'b0);

      // R8: 300 copies wrap an 8-bit counter to 44
      stim.delete();
      for (int k = 0; k < 300; k++) stim.push_back(8'h07);
      run_case("R8 wrap", 1'b0, 1'b0, 1'b0);

      // R10: start pulse in the middle of a stream is ignored
      stim.delete();
      for (int k = 0; k < 20; k++) stim.push_back(8'((k * 13) % 256));
      run_case("R10 busy start", 1'b0, 1'b0, 1'b1);

      // R3 R4: every symbol once, including 0 and 255
      stim.delete();
      for (int k = 0; k < 256; k++) stim.push_back(8'(255 - k));
      run_case("R3 R4 all symbols", 1'b1, 1'b1, 1'b0);

      finish_sim();
   end
endmodule